// File: doc/BRIEF.md
# Serial Byte Transmitter with Optional Parity

This block turns one 8-bit byte into an asynchronous serial frame on a single output line. A caller places a byte on the data input and pulses the start strobe for one clock while the block is idle. The block then sends a low start bit, the eight data bits with the least significant bit first, an optional parity bit, and a high stop bit. Each bit lasts a fixed number of clock cycles, and the busy flag is high for the whole frame.

Two elaboration-time parameters shape the frame. One switches the parity bit on. The other chooses whether that bit makes the count of ones even or odd. When parity is off, the parity register and its frame state are not built at all. A bound checker watches the framing rules during simulation. It halts the run if the data bit index ever leaves its legal range.

Top module: `serial_byte_tx`

## Requirements
- R1: When busy is low, and from reset onward, the line `tx_o` is 1.
- R2: Each bit of a frame is held on `tx_o` for `CYCLES_PER_BIT` consecutive cycles. Bit 0 of the frame is a start bit of value 0. The last bit is a stop bit of value 1.
- R3: Frame bits 1 to 8 carry `data[0]` to `data[7]` in that order. The internal data bit index never leaves the range 0 to 7 during the data phase, and the simulation is stopped if it does.
- R4: A strobe sampled high on a rising edge while idle is accepted. The start bit and `busy_o` begin in the cycle right after that edge. `busy_o` stays high through the last cycle of the stop bit.
- R5: A strobe that arrives while `busy_o` is high is ignored, and the frame in progress is sent unchanged.
- R6: The byte is captured when the strobe is accepted. Later changes on `data_i` do not alter the frame.
- R7: A frame lasts 10 bit periods when `PARITY_ON` is 0. It lasts 11 bit periods when `PARITY_ON` is 1.
- R8: With parity on, frame bit 9 is the parity bit and sits between the last data bit and the stop bit. It equals the XOR of the 8 captured data bits when `PARITY_ODD` is 0, and the inverse of that XOR when `PARITY_ODD` is 1.
- R9: An active-low reset aborts any frame and returns the block to idle (line high, busy low). A strobe held high in the first idle cycle after a frame is accepted, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Send request, sampled on the rising edge |
| data_i | input | 8 | Byte to send, captured when the request is accepted |
| tx_o | output | 1 | Serial output line |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
The checker tests these rules on every cycle:
- the line is high while idle;
- the start bit is low and the stop bit is high;
- the data index stays in range;
- the parity bit matches the captured byte;
- an accepted request raises busy with a low line;
- the held byte stays stable under strobes that arrive while busy;
- each frame has the right length.

Only the bench scenarios can show the following:
- every data bit appears in order, for all 256 byte values;
- changing `data_i` after acceptance leaves the frame unchanged;
- a reset in the middle of a frame leaves a clean idle state;
- a request in the first idle cycle starts the next frame at once.

Three builds are driven side by side: even parity, odd parity, and no parity.

// File: rtl/serial_byte_tx.sv
module serial_byte_tx #(
  parameter int CYCLES_PER_BIT = 16,
  parameter int PARITY_ON      = 0,
  parameter int PARITY_ODD     = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       tx_o,
  output logic       busy_o
);
  localparam int CW = (CYCLES_PER_BIT > 1) ? $clog2(CYCLES_PER_BIT) : 1;
  localparam logic [CW-1:0] TICK_LAST = CW'(CYCLES_PER_BIT - 1);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_START = 3'd1;
  localparam logic [2:0] S_DATA  = 3'd2;
  localparam logic [2:0] S_PAR   = 3'd3;
  localparam logic [2:0] S_STOP  = 3'd4;
  localparam logic [2:0] S_AFTER_DATA = (PARITY_ON != 0) ? S_PAR : S_STOP;

  logic [2:0]    state_q;
  logic [CW-1:0] tick_q;
  logic [3:0]    idx_q;
  logic [7:0]    data_q;
  logic          par_bit;

  wire accept  = (state_q == S_IDLE) && start_i;
  wire bit_end = (tick_q == TICK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tick_q  <= '0;
      idx_q   <= '0;
      data_q  <= '0;
    end else if (accept) begin
      state_q <= S_START;
      tick_q  <= '0;
      data_q  <= data_i;
    end else if (state_q != S_IDLE) begin
      tick_q <= bit_end ? '0 : tick_q + 1'b1;
      if (bit_end) begin
        case (state_q)
          S_START: begin
            state_q <= S_DATA;
            idx_q   <= '0;
          end
          S_DATA: begin
            if (idx_q == 4'd7) state_q <= S_AFTER_DATA;
            else               idx_q   <= idx_q + 4'd1;
          end
          S_PAR:   state_q <= S_STOP;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  generate
    if (PARITY_ON != 0) begin : gen_parity
      logic par_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      par_q <= 1'b0;
        else if (accept) par_q <= (^data_i) ^ (PARITY_ODD != 0);
      end
      assign par_bit = par_q;
    end else begin : gen_no_parity
      assign par_bit = 1'b1;
    end
  endgenerate

  always_comb begin
    case (state_q)
      S_START: tx_o = 1'b0;
      S_DATA:  tx_o = data_q[idx_q[2:0]];
      S_PAR:   tx_o = par_bit;
      default: tx_o = 1'b1;
    endcase
  end

  assign busy_o = (state_q != S_IDLE);
endmodule

module serial_byte_tx_chk #(
  parameter int CPB     = 16,
  parameter int PAR_ON  = 0,
  parameter int PAR_ODD = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       tx_o,
  input logic [2:0] state_q,
  input logic [3:0] idx_q,
  input logic [7:0] data_q
);
  localparam int FRAME_CYC = ((PAR_ON != 0) ? 11 : 10) * CPB;

  logic [31:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (busy_o) len_q <= len_q + 32'd1;
    else             len_q <= '0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (state_q == 3'd1)
        p_start_low_r2: assert (tx_o == 1'b0) else $error("start bit not low");
      if (state_q == 3'd4)
        p_stop_high_r2: assert (tx_o == 1'b1) else $error("stop bit not high");
      if (state_q == 3'd2)
        p_no_overflow_r3: assert (idx_q <= 4'd7) else $fatal(1, "data bit index overflow");
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o);
  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !tx_o));
  p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(data_q));
  p_frame_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (len_q == 32'(FRAME_CYC)));
  p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'd3) |-> (tx_o == ((^data_q) ^ (PAR_ODD != 0))));
endmodule

bind serial_byte_tx serial_byte_tx_chk #(
  .CPB(CYCLES_PER_BIT), .PAR_ON(PARITY_ON), .PAR_ODD(PARITY_ODD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .tx_o(tx_o),
  .state_q(state_q), .idx_q(idx_q), .data_q(data_q)
);

// File: tb/sim_serial_byte_tx.sv
`timescale 1ns/1ps
module sim_serial_byte_tx;
  localparam int CPB = 4;
  localparam int LONG = 11 * CPB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic tx0, tx1, tx2, busy0, busy1, busy2;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  serial_byte_tx #(.CYCLES_PER_BIT(CPB), .PARITY_ON(1), .PARITY_ODD(0)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i), .tx_o(tx0), .busy_o(busy0));
  serial_byte_tx #(.CYCLES_PER_BIT(CPB), .PARITY_ON(1), .PARITY_ODD(1)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i), .tx_o(tx1), .busy_o(busy1));
  serial_byte_tx #(.CYCLES_PER_BIT(CPB), .PARITY_ON(0), .PARITY_ODD(0)) u2 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i), .tx_o(tx2), .busy_o(busy2));

  function automatic logic exp_tx(input logic [7:0] b, input bit par, input bit odd, input int i);
    int k = i / CPB;
    if (k == 0) return 1'b0;
    if (k <= 8) return b[k-1];
    if (par && k == 9) return (^b) ^ odd;
    return 1'b1;
  endfunction

  function automatic logic exp_busy(input bit par, input int i);
    return (i / CPB) < (par ? 11 : 10);
  endfunction

  function automatic string tag_of(input bit par, input bit inj, input int i);
    int k = i / CPB;
    if (i == 0) return "R9 R4 R2";
    if (k == 0) return "R2";
    if (k <= 8) return (inj && k > 3) ? "R5" : "R3 R6";
    if (par && k == 9) return "R8";
    if (k == (par ? 10 : 9)) return "R2 R7";
    return "R1 R7";
  endfunction

  task automatic chk(input string name, input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, name, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk("u0 tx", tx0, 1'b1, tag);   chk("u0 busy", busy0, 1'b0, tag);
    chk("u1 tx", tx1, 1'b1, tag);   chk("u1 busy", busy1, 1'b0, tag);
    chk("u2 tx", tx2, 1'b1, tag);   chk("u2 busy", busy2, 1'b0, tag);
  endtask

  task automatic run_frame(input logic [7:0] b, input bit inj);
    data_i = b;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    data_i = ~b;
    for (int i = 0; i <= LONG; i++) begin
      chk("u0 tx", tx0, exp_tx(b, 1, 0, i), tag_of(1, inj, i));
      chk("u1 tx", tx1, exp_tx(b, 1, 1, i), tag_of(1, inj, i));
      chk("u2 tx", tx2, exp_tx(b, 0, 0, i), tag_of(0, inj, i));
      chk("u0 busy", busy0, exp_busy(1, i), "R4");
      chk("u1 busy", busy1, exp_busy(1, i), "R4");
      chk("u2 busy", busy2, exp_busy(0, i), "R4");
      if (inj && i == 3 * CPB) begin
        start_i = 1'b1;
        data_i = b ^ 8'h5A;
      end else begin
        start_i = 1'b0;
        data_i = ~b;
      end
      if (i < LONG) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R9 reset R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    for (int b = 0; b < 256; b++) run_frame(8'(b), (b % 16) == 5);
    data_i = 8'hC3;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R9 mid-frame reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R9 after reset");
    run_frame(8'hA5, 1'b1);
    run_frame(8'h00, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule